// File: doc/BRIEF.md
# PCI Memory Target with Exclusive-Access Retry

This block is the target side of a 32-bit PCI bus that serves memory reads and memory writes to a small bank of internal 32-bit registers. It watches FRAME for the start of a transaction and decodes the command and address in the first clock. When it claims the access it answers with medium DEVSEL timing, then completes data phases through the IRDY/TRDY handshake. Bursts run for as long as the initiator holds FRAME, and the word pointer advances once per completed data phase. Writes honour the active-low byte enables lane by lane.

The target also keeps PCI exclusive-access state. An access that claims it with LOCK high in the address clock and LOCK low one clock later makes it a locked resource. While locked, any claimed access that finds LOCK already low in its address clock comes from another master. That access gets a retry termination and moves no data. The owner continues with LOCK high in its address clock and is served normally. The lock ends on the first clock edge that sees LOCK and FRAME both high.

Every tri-state pin the target drives is split into a value output and an enable output. Pins the target only observes are plain inputs. Parity, configuration space, initiator operation and bus parking are outside this block.

Top module: `pci_lock_target`

## Requirements
- R1: An access is claimed only if four conditions hold in its address clock (the first clock with FRAME low after a clock with FRAME high). C/BE must carry 0110 (memory read) or 0111 (memory write). AD[1:0] must be 00. AD[31:LOW] must equal the same bits of BASE_ADDR, where LOW = log2(WORDS)+2. Any other access leaves every output enable low and the registers unchanged.
- R2: For a claimed access, the outputs TRDY, STOP and DEVSEL are driven high in the first clock after the address clock. DEVSEL is driven low in the second clock after it.
- R3: On a claimed read, TRDY goes low in the second clock after the address clock. AD is driven, with the addressed word, exactly in the clocks where TRDY is driven low.
- R4: On a completed write data phase, byte lane k (AD[8k+7:8k]) of the addressed word is written only if C/BE bit k is low. The other lanes keep their value.
- R5: A data phase completes only on a clock edge where IRDY and TRDY are both low. The word index, taken from AD[LOW-1:2] in the address clock, advances by one modulo WORDS on each completion.
- R6: When a data phase completes on an edge where FRAME is high, DEVSEL and TRDY are driven high for one clock. All output enables are low in the clock after that.
- R7: The target becomes locked after two conditions in a row. First, an access it claims while unlocked has LOCK high in its address clock. Second, LOCK is low on the next edge. If LOCK stays high on that next edge, no lock is formed.
- R8: While locked, a claimed access with LOCK low in its address clock is retried. From the second clock after the address clock, DEVSEL and STOP are low and TRDY is high. STOP is held until FRAME is sampled high, and no register is written.
- R9: While locked, a claimed access with LOCK high in its address clock is served like an unlocked access.
- R10: The lock is cleared on an edge where LOCK and FRAME are both high. After that, accesses with LOCK low in the address clock are served normally.
- R11: While reset is low, every output enable is low. Reset clears all registers to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | PCI clock |
| rst_n | input | 1 | PCI reset, active low, asserted asynchronously |
| ad_i | input | 32 | Address/data bus as seen on the pins |
| ad_o | output | 32 | Read data driven onto AD |
| ad_oe | output | 1 | Enable for AD output |
| cbe_n_i | input | 4 | Command in the address clock, byte enables (active low) in data phases |
| frame_n_i | input | 1 | FRAME from the initiator, active low |
| irdy_n_i | input | 1 | Initiator ready, active low |
| lock_n_i | input | 1 | LOCK pin, active low |
| trdy_n_o | output | 1 | Target ready value, active low |
| trdy_oe | output | 1 | Enable for TRDY |
| stop_n_o | output | 1 | Stop request value, active low |
| stop_oe | output | 1 | Enable for STOP |
| devsel_n_o | output | 1 | Device select value, active low |
| devsel_oe | output | 1 | Enable for DEVSEL |

## Verification
The bench builds the block with WORDS = 16 and BASE_ADDR = 32'h4000_0C00, a window that does not start at zero. With these values, an access 64 bytes above the window can be shown to be rejected rather than folded back onto word 0. A four-word burst that starts at word 14 crosses the index wrap from 15 to 0. A small word count also keeps the whole register bank inside a readback of a few transactions, so lock and retry sequences can be checked for stray writes.

// File: rtl/pci_tgt_pkg.sv
package pci_tgt_pkg;
  localparam logic [3:0] CMD_MEM_RD = 4'b0110;
  localparam logic [3:0] CMD_MEM_WR = 4'b0111;
  localparam int         LANES      = 4;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CLAIM,
    ST_XFER,
    ST_RETRY,
    ST_TURN
  } tgt_state_e;
endpackage

// File: rtl/pci_tgt_decode.sv
module pci_tgt_decode
  import pci_tgt_pkg::*;
#(
  parameter logic [31:0] BASE_ADDR = 32'h0000_1000,
  parameter int          IDX_W     = 4
) (
  input  logic [31:0]      ad,
  input  logic [3:0]       cmd,
  input  logic             addr_ph,
  output logic             hit,
  output logic             is_read,
  output logic [IDX_W-1:0] idx
);
  localparam int LOW = IDX_W + 2;

  logic cmd_ok;
  logic win_ok;
  logic lin_ok;

  always_comb begin
    cmd_ok  = (cmd == CMD_MEM_RD) || (cmd == CMD_MEM_WR);
    win_ok  = (ad[31:LOW] == BASE_ADDR[31:LOW]);
    lin_ok  = (ad[1:0] == 2'b00);
    hit     = addr_ph && cmd_ok && win_ok && lin_ok;
    is_read = (cmd == CMD_MEM_RD);
    idx     = ad[LOW-1:2];
  end
endmodule

// File: rtl/pci_tgt_regbank.sv
module pci_tgt_regbank
  import pci_tgt_pkg::*;
#(
  parameter int WORDS = 16,
  parameter int IDX_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [31:0]      wr_data,
  input  logic [3:0]       be_n,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [31:0]      rd_data
);
  logic [31:0] words [WORDS];

  for (genvar w = 0; w < WORDS; w++) begin : g_word
    logic [31:0] word_q;
    logic [31:0] word_d;
    logic        sel;

    always_comb begin
      sel    = wr_en && (wr_idx == IDX_W'(w));
      word_d = word_q;
      for (int b = 0; b < LANES; b++) begin
        if (!be_n[b]) word_d[8*b +: 8] = wr_data[8*b +: 8];
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   word_q <= '0;
      else if (sel) word_q <= word_d;
    end

    assign words[w] = word_q;
  end

  assign rd_data = words[rd_idx];
endmodule

// File: rtl/pci_tgt_lock.sv
module pci_tgt_lock (
  input  logic clk,
  input  logic rst_n,
  input  logic hit,
  input  logic lock_n,
  input  logic frame_n,
  output logic locked
);
  logic pend_q, pend_d;
  logic lock_q, lock_d;

  always_comb begin
    pend_d = hit && lock_n && !lock_q;
    lock_d = lock_q;
    if (lock_q && frame_n && lock_n) lock_d = 1'b0;
    if (pend_q && !lock_n)           lock_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      lock_q <= 1'b0;
    end else begin
      pend_q <= pend_d;
      lock_q <= lock_d;
    end
  end

  assign locked = lock_q;
endmodule

// File: rtl/pci_tgt_fsm.sv
module pci_tgt_fsm
  import pci_tgt_pkg::*;
#(
  parameter int IDX_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hit,
  input  logic             hit_read,
  input  logic [IDX_W-1:0] hit_idx,
  input  logic             retry_req,
  input  logic             irdy_n,
  input  logic             frame_n,
  output tgt_state_e       state,
  output logic             rd_mode,
  output logic [IDX_W-1:0] idx,
  output logic             done
);
  tgt_state_e       st_q, st_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic             rd_q, rd_d;
  logic             rty_q, rty_d;

  always_comb begin
    st_d  = st_q;
    idx_d = idx_q;
    rd_d  = rd_q;
    rty_d = rty_q;
    done  = (st_q == ST_XFER) && !irdy_n;
    case (st_q)
      ST_IDLE, ST_TURN: begin
        st_d = ST_IDLE;
        if (hit) begin
          st_d  = ST_CLAIM;
          idx_d = hit_idx;
          rd_d  = hit_read;
          rty_d = retry_req;
        end
      end
      ST_CLAIM: st_d = rty_q ? ST_RETRY : ST_XFER;
      ST_XFER: begin
        if (done) begin
          idx_d = idx_q + 1'b1;
          if (frame_n) st_d = ST_TURN;
        end
      end
      ST_RETRY: if (frame_n) st_d = ST_TURN;
      default:  st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      idx_q <= '0;
      rd_q  <= 1'b0;
      rty_q <= 1'b0;
    end else begin
      st_q  <= st_d;
      idx_q <= idx_d;
      rd_q  <= rd_d;
      rty_q <= rty_d;
    end
  end

  assign state   = st_q;
  assign rd_mode = rd_q;
  assign idx     = idx_q;
endmodule

// File: rtl/pci_lock_target.sv
module pci_lock_target
  import pci_tgt_pkg::*;
#(
  parameter logic [31:0] BASE_ADDR = 32'h0000_1000,
  parameter int          WORDS     = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [31:0] ad_i,
  output logic [31:0] ad_o,
  output logic        ad_oe,
  input  logic [3:0]  cbe_n_i,
  input  logic        frame_n_i,
  input  logic        irdy_n_i,
  input  logic        lock_n_i,
  output logic        trdy_n_o,
  output logic        trdy_oe,
  output logic        stop_n_o,
  output logic        stop_oe,
  output logic        devsel_n_o,
  output logic        devsel_oe
);
  localparam int IDX_W = $clog2(WORDS);

  logic             rst_meta, rst_int;
  logic             frame_q;
  logic             addr_ph;
  logic             hit, hit_read;
  logic [IDX_W-1:0] hit_idx;
  logic             locked;
  tgt_state_e       state;
  logic             rd_mode, done;
  logic [IDX_W-1:0] idx;
  logic [31:0]      rd_data;

  // reset asserts at once, releases on the second clock edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_int  <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_int  <= rst_meta;
    end
  end

  always_ff @(posedge clk or negedge rst_int) begin
    if (!rst_int) frame_q <= 1'b1;
    else          frame_q <= frame_n_i;
  end

  assign addr_ph = !frame_n_i && frame_q;

  pci_tgt_decode #(.BASE_ADDR(BASE_ADDR), .IDX_W(IDX_W)) u_dec (
    .ad(ad_i), .cmd(cbe_n_i), .addr_ph(addr_ph),
    .hit(hit), .is_read(hit_read), .idx(hit_idx)
  );

  pci_tgt_lock u_lock (
    .clk(clk), .rst_n(rst_int), .hit(hit), .lock_n(lock_n_i),
    .frame_n(frame_n_i), .locked(locked)
  );

  pci_tgt_fsm #(.IDX_W(IDX_W)) u_fsm (
    .clk(clk), .rst_n(rst_int), .hit(hit), .hit_read(hit_read),
    .hit_idx(hit_idx), .retry_req(locked && !lock_n_i),
    .irdy_n(irdy_n_i), .frame_n(frame_n_i), .state(state),
    .rd_mode(rd_mode), .idx(idx), .done(done)
  );

  pci_tgt_regbank #(.WORDS(WORDS), .IDX_W(IDX_W)) u_regs (
    .clk(clk), .rst_n(rst_int), .wr_en(done && !rd_mode), .wr_idx(idx),
    .wr_data(ad_i), .be_n(cbe_n_i), .rd_idx(idx), .rd_data(rd_data)
  );

  always_comb begin
    trdy_oe    = (state != ST_IDLE);
    stop_oe    = trdy_oe;
    devsel_oe  = trdy_oe;
    trdy_n_o   = (state != ST_XFER);
    stop_n_o   = (state != ST_RETRY);
    devsel_n_o = !((state == ST_XFER) || (state == ST_RETRY));
    ad_oe      = (state == ST_XFER) && rd_mode;
    ad_o       = ad_oe ? rd_data : '0;
  end
endmodule

// File: rtl/pci_lock_target_chk.sv
module pci_lock_target_chk (
  input logic clk,
  input logic rst_n,
  input logic frame_n,
  input logic irdy_n,
  input logic ad_oe,
  input logic trdy_n,
  input logic trdy_oe,
  input logic stop_n,
  input logic stop_oe,
  input logic devsel_n,
  input logic devsel_oe
);
  logic trdy_on, stop_on, dev_on;
  assign trdy_on = trdy_oe && !trdy_n;
  assign stop_on = stop_oe && !stop_n;
  assign dev_on  = devsel_oe && !devsel_n;

  p_trdy_needs_devsel_r3: assert property (@(posedge clk) disable iff (!rst_n)
    trdy_on |-> dev_on);
  p_ad_only_with_trdy_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ad_oe |-> trdy_on);
  p_devsel_after_drive_r2: assert property (@(posedge clk) disable iff (!rst_n)
    dev_on |-> $past(devsel_oe));
  p_retry_no_trdy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    stop_on |-> (trdy_n && dev_on));
  p_stop_held_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_on && !frame_n) |=> stop_on);
  p_release_after_last_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (trdy_on && !irdy_n && frame_n) |=> (devsel_oe && devsel_n && trdy_n));

  always @(posedge clk) begin
    if (!rst_n) begin
      p_off_in_reset_r11: assert (!trdy_oe && !stop_oe && !devsel_oe && !ad_oe);
    end
  end
endmodule

bind pci_lock_target pci_lock_target_chk u_chk (
  .clk(clk), .rst_n(rst_int), .frame_n(frame_n_i), .irdy_n(irdy_n_i),
  .ad_oe(ad_oe), .trdy_n(trdy_n_o), .trdy_oe(trdy_oe), .stop_n(stop_n_o),
  .stop_oe(stop_oe), .devsel_n(devsel_n_o), .devsel_oe(devsel_oe)
);

// File: tb/tb_pci_lock_target.sv
module tb_pci_lock_target;
  localparam int          CLK_PERIOD = 10;
  localparam logic [31:0] BASE       = 32'h4000_0C00;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] ad_drv = '0;
  logic        ad_en = 1'b0;
  logic [31:0] ad_i, ad_o;
  logic        ad_oe;
  logic [3:0]  cbe_n = 4'hF;
  logic        frame_n = 1'b1, irdy_n = 1'b1, lock_n = 1'b1;
  logic        trdy_n_o, trdy_oe, stop_n_o, stop_oe, devsel_n_o, devsel_oe;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  logic [31:0] wbuf [16];
  logic [31:0] rbuf [16];

  assign ad_i = ad_en ? ad_drv : 32'h0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pci_lock_target #(.BASE_ADDR(BASE), .WORDS(16)) dut (
    .clk(clk), .rst_n(rst_n), .ad_i(ad_i), .ad_o(ad_o), .ad_oe(ad_oe),
    .cbe_n_i(cbe_n), .frame_n_i(frame_n), .irdy_n_i(irdy_n), .lock_n_i(lock_n),
    .trdy_n_o(trdy_n_o), .trdy_oe(trdy_oe), .stop_n_o(stop_n_o), .stop_oe(stop_oe),
    .devsel_n_o(devsel_n_o), .devsel_oe(devsel_oe)
  );

  // behavioural reference: 0 idle, 1 claim, 2 data, 3 retry, 4 turnaround
  int          m_st = 0, m_idx = 0, m_rc = 0;
  bit          m_rd = 0, m_rty = 0, m_lock = 0, m_pend = 0, m_fq = 1;
  logic [31:0] m_mem [16];

  always @(posedge clk) begin
    bit adr, hit, nl;
    if (!rst_n) begin
      m_rc = 0; m_st = 0; m_lock = 0; m_pend = 0; m_fq = 1; m_idx = 0;
      for (int i = 0; i < 16; i++) m_mem[i] = 32'h0;
    end else if (m_rc < 2) begin
      m_rc++;
    end else begin
      adr = !frame_n && m_fq;
      hit = adr && (cbe_n == 4'b0110 || cbe_n == 4'b0111) &&
            (ad_i[31:6] == BASE[31:6]) && (ad_i[1:0] == 2'b00);
      nl = m_lock;
      if (m_lock && frame_n && lock_n) nl = 0;
      if (m_pend && !lock_n) nl = 1;
      case (m_st)
        0, 4: begin
          m_st = 0;
          if (hit) begin
            m_st = 1; m_rd = (cbe_n == 4'b0110); m_idx = int'(ad_i[5:2]);
            m_rty = m_lock && !lock_n;
          end
        end
        1: m_st = m_rty ? 3 : 2;
        2: if (!irdy_n) begin
             if (!m_rd)
               for (int b = 0; b < 4; b++)
                 if (!cbe_n[b]) m_mem[m_idx][8*b +: 8] = ad_i[8*b +: 8];
             m_idx = (m_idx + 1) % 16;
             if (frame_n) m_st = 4;
           end
        3: if (frame_n) m_st = 4;
        default: m_st = 0;
      endcase
      m_pend = hit && lock_n && !m_lock;
      m_lock = nl;
    end
  end

  task automatic fail_line(input string req, input logic [31:0] act, input logic [31:0] exp);
    bad++;
    $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
  endtask

  always @(negedge clk) begin
    bit e_oe, e_dev, e_trdy, e_stop, e_ad;
    e_oe   = (m_st != 0);
    e_dev  = (m_st == 2 || m_st == 3);
    e_trdy = (m_st == 2);
    e_stop = (m_st == 3);
    e_ad   = e_trdy && m_rd;
    total++;
    if ({trdy_oe, stop_oe, devsel_oe} !== {3{e_oe}})
      fail_line("R6 enables", {29'h0, trdy_oe, stop_oe, devsel_oe}, {29'h0, {3{e_oe}}});
    if (devsel_n_o !== !e_dev) fail_line("R2 devsel", {31'h0, devsel_n_o}, {31'h0, !e_dev});
    if (trdy_n_o !== !e_trdy)  fail_line("R5 trdy", {31'h0, trdy_n_o}, {31'h0, !e_trdy});
    if (stop_n_o !== !e_stop)  fail_line("R8 stop", {31'h0, stop_n_o}, {31'h0, !e_stop});
    if (ad_oe !== e_ad)        fail_line("R3 ad_oe", {31'h0, ad_oe}, {31'h0, e_ad});
    if (e_ad && ad_o !== m_mem[m_idx]) fail_line("R3 read data", ad_o, m_mem[m_idx]);
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) fail_line(req, act, exp);
  endtask

  task automatic xfer(input logic [3:0] cmd, input logic [31:0] addr, input int n,
                      input logic lk_a, input logic lk_d, input logic [3:0] be,
                      input int stall_at, input int stall_len,
                      output bit retried, output bit claimed);
    int k = 0;
    int guard = 0;
    retried = 0; claimed = 0;
    @(posedge clk); #1;
    frame_n = 1'b0; ad_en = 1'b1; ad_drv = addr; cbe_n = cmd; lock_n = lk_a;
    @(posedge clk); #1;
    lock_n = lk_d; cbe_n = be; frame_n = (n == 1); ad_en = cmd[0]; ad_drv = wbuf[0];
    irdy_n = 1'b0;
    if (stall_at == 0) begin
      irdy_n = 1'b1;
      repeat (stall_len) @(posedge clk);
      #1; irdy_n = 1'b0;
    end
    forever begin
      @(negedge clk);
      if (devsel_oe && !devsel_n_o) claimed = 1;
      if (trdy_oe && !trdy_n_o && !irdy_n) begin
        rbuf[k] = ad_o; k++;
        @(posedge clk); #1;
        if (k == n) break;
        frame_n = (k == n - 1); ad_drv = wbuf[k];
        if (k == stall_at) begin
          irdy_n = 1'b1;
          repeat (stall_len) @(posedge clk);
          #1; irdy_n = 1'b0;
        end
      end else if (stop_oe && !stop_n_o) begin
        retried = 1;
        @(posedge clk); #1; frame_n = 1'b1;
        guard = 0;
        do begin @(negedge clk); guard++; end while (stop_oe && !stop_n_o && guard < 10);
        @(posedge clk); #1;
        break;
      end else begin
        guard++;
        @(posedge clk); #1;
        if (guard > 6) begin frame_n = 1'b1; @(posedge clk); #1; break; end
      end
    end
    frame_n = 1'b1; irdy_n = 1'b1; ad_en = 1'b0; cbe_n = 4'hF;
  endtask

  task automatic rd_word(input int idx, input logic lk_a, input logic lk_d, output logic [31:0] d);
    bit r, c;
    xfer(4'b0110, BASE + 32'(idx * 4), 1, lk_a, lk_d, 4'h0, -1, 0, r, c);
    d = rbuf[0];
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      bad++;
      $display("FAIL watchdog actual=running expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    bit r, c;
    logic [31:0] d;
    for (int i = 0; i < 16; i++) wbuf[i] = 32'h0;
    repeat (3) @(negedge clk);
    check(!trdy_oe && !stop_oe && !devsel_oe && !ad_oe, "R11 enables in reset",
          {28'h0, trdy_oe, stop_oe, devsel_oe, ad_oe}, 32'h0);
    @(posedge clk); #1; rst_n = 1'b1;
    repeat (4) @(posedge clk);

    rd_word(0, 1'b1, 1'b1, d);
    check(d === 32'h0, "R11 cleared word", d, 32'h0);

    wbuf[0] = 32'h1122_3344;
    xfer(4'b0111, BASE + 32'd12, 1, 1'b1, 1'b1, 4'h0, -1, 0, r, c);
    check(c && !r, "R2 write claimed", {31'h0, c}, 32'h1);
    rd_word(3, 1'b1, 1'b1, d);
    check(d === 32'h1122_3344, "R3 readback", d, 32'h1122_3344);

    wbuf[0] = 32'hAABB_CCDD;
    xfer(4'b0111, BASE + 32'd12, 1, 1'b1, 1'b1, 4'b1010, -1, 0, r, c);
    rd_word(3, 1'b1, 1'b1, d);
    check(d === 32'h11BB_33DD, "R4 byte lanes", d, 32'h11BB_33DD);

    wbuf[0] = 32'hCAFE_0014; wbuf[1] = 32'hCAFE_0015;
    wbuf[2] = 32'hCAFE_0000; wbuf[3] = 32'hCAFE_0001;
    xfer(4'b0111, BASE + 32'd56, 4, 1'b1, 1'b1, 4'h0, 1, 2, r, c);
    xfer(4'b0110, BASE + 32'd56, 4, 1'b1, 1'b1, 4'h0, 2, 3, r, c);
    check(rbuf[0] === 32'hCAFE_0014, "R5 burst word14", rbuf[0], 32'hCAFE_0014);
    check(rbuf[2] === 32'hCAFE_0000, "R5 burst wrap word0", rbuf[2], 32'hCAFE_0000);
    check(rbuf[3] === 32'hCAFE_0001, "R5 burst word1", rbuf[3], 32'hCAFE_0001);

    wbuf[0] = 32'h5555_5555;
    xfer(4'b0011, BASE + 32'd20, 1, 1'b1, 1'b1, 4'h0, -1, 0, r, c);
    check(!c, "R1 io command ignored", {31'h0, c}, 32'h0);
    wbuf[0] = 32'hDEAD_BEEF;
    xfer(4'b0111, BASE + 32'd64, 1, 1'b1, 1'b1, 4'h0, -1, 0, r, c);
    check(!c, "R1 outside window", {31'h0, c}, 32'h0);
    xfer(4'b0111, BASE + 32'd1, 1, 1'b1, 1'b1, 4'h0, -1, 0, r, c);
    check(!c, "R1 nonlinear order", {31'h0, c}, 32'h0);
    rd_word(5, 1'b1, 1'b1, d);
    check(d === 32'h0, "R1 word5 untouched", d, 32'h0);
    rd_word(0, 1'b1, 1'b1, d);
    check(d === 32'hCAFE_0000, "R1 word0 untouched", d, 32'hCAFE_0000);

    wbuf[0] = 32'h0808_0808;
    xfer(4'b0111, BASE + 32'd32, 1, 1'b1, 1'b1, 4'h0, -1, 0, r, c);
    xfer(4'b0110, BASE + 32'd36, 1, 1'b0, 1'b0, 4'h0, -1, 0, r, c);
    check(!r, "R7 no lock without low LOCK", {31'h0, r}, 32'h0);
    lock_n = 1'b1; repeat (2) @(posedge clk);

    wbuf[0] = 32'h6666_6666;
    xfer(4'b0111, BASE + 32'd24, 1, 1'b1, 1'b0, 4'h0, -1, 0, r, c);
    repeat (2) @(posedge clk);
    wbuf[0] = 32'h7777_7777;
    xfer(4'b0111, BASE + 32'd28, 1, 1'b0, 1'b0, 4'h0, -1, 0, r, c);
    check(r, "R7 lock formed and R8 retry", {31'h0, r}, 32'h1);
    rd_word(6, 1'b1, 1'b0, d);
    check(d === 32'h6666_6666, "R9 owner served", d, 32'h6666_6666);
    xfer(4'b0110, BASE + 32'd28, 1, 1'b0, 1'b0, 4'h0, -1, 0, r, c);
    check(r, "R8 retry persists", {31'h0, r}, 32'h1);

    lock_n = 1'b1; repeat (2) @(posedge clk);
    rd_word(7, 1'b0, 1'b0, d);
    check(d === 32'h0, "R8 retried write dropped", d, 32'h0);
    wbuf[0] = 32'h7070_7070;
    xfer(4'b0111, BASE + 32'd28, 1, 1'b0, 1'b0, 4'h0, -1, 0, r, c);
    check(!r && c, "R10 unlocked access served", {31'h0, r}, 32'h0);
    lock_n = 1'b1;
    rd_word(7, 1'b1, 1'b1, d);
    check(d === 32'h7070_7070, "R10 data after unlock", d, 32'h7070_7070);

    repeat (4) @(posedge clk);
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule